// File: doc/BRIEF.md
# Programmable Page Permission Checker

The block decides whether one memory access may go ahead. Each check names a 4-bit access code taken from a page-table entry, the page's present bit, the privilege level of the requester and the kind of access: read, write or execute. The access code selects one of sixteen rows in a rights table that software can load. Each row holds a read, write and execute right for each of four privilege levels: user, supervisor, executive and kernel. Because the table can be loaded, the meaning of each code is set by software and is not fixed in hardware.

The table is held as four separate banks of sixteen 3-bit rights, one bank per privilege level. A check reads only the bank of its own level. A write updates one 3-bit rights triple, for one code at one level. The result of a check is registered and appears on the cycle after the request. It gives allow or deny and a 2-bit fault reason. After reset the table follows a hierarchical rule: a more privileged level never has fewer rights than a less privileged one.

Top module: `perm_checker`

## Requirements
- R1: After reset, the row for code c holds a rights class k = c mod 4, where k=0 is R, k=1 is RE, k=2 is RW and k=3 is RWE. Levels with number >= 3 - (c div 4) hold that class and all lower levels hold no rights. So code 0 gives kernel R only and code 15 gives RWE at every level. Levels are numbered 0 user, 1 supervisor, 2 executive, 3 kernel. In a rights triple, bit 0 is read, bit 1 is write and bit 2 is execute.
- R2: A request with `chk_valid` high gives `res_valid` high on the next cycle. A cycle without a request gives `res_valid`, `res_allow` and `res_fault` all zero on the next cycle.
- R3: A present request is allowed exactly when the table bit for its code, its level and its kind is set. The kind is encoded 0 read, 1 write, 2 execute, and this value is also the bit index in the rights triple. An allowed result has fault reason 0.
- R4: A request with `chk_present` low is always denied with fault reason 1, whatever the code, level, kind and table contents.
- R5: A present request whose right is missing is denied with fault reason 2. Kind value 3 is reserved and is always denied with fault reason 2.
- R6: A write with `wr_en` high replaces only the triple at (`wr_idx`, `wr_lvl`). Every other code and level keeps its rights, and checks made later see the new triple.
- R7: If a write and a check fall in the same cycle on the same code and level, the check is judged on the rights held before that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Table write strobe |
| wr_idx | input | 4 | Access code of the row being written |
| wr_lvl | input | 2 | Privilege level whose triple is written |
| wr_rights | input | 3 | New rights: bit 0 read, bit 1 write, bit 2 execute |
| chk_valid | input | 1 | Check request strobe |
| chk_code | input | 4 | Access code from the page-table entry |
| chk_present | input | 1 | Present bit of the page-table entry |
| chk_lvl | input | 2 | Privilege level of the requester |
| chk_kind | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 reserved |
| res_valid | output | 1 | Result valid, one cycle after the request |
| res_allow | output | 1 | Access allowed |
| res_fault | output | 2 | Fault reason: 0 none, 1 not present, 2 missing right |

## Verification
A table write and a check can fall in the same cycle. When both target the same code and level, the check must see the old triple. The bench provokes this by driving `wr_en` and `chk_valid` together onto one triple with new rights that change the answer. It expects the old verdict on the next cycle, then checks again and expects the new verdict. It also sweeps every code, level and kind against a model of the table kept in the bench, first with the reset contents and then after a full reload, and it covers absent pages and partial updates.

// File: rtl/perm_pkg.sv
package perm_pkg;

    localparam int CODE_W  = 4;
    localparam int LVL_W   = 2;
    localparam int KIND_W  = 2;
    localparam int RIGHT_W = 3;
    localparam int NUM_LVL = 1 << LVL_W;
    localparam int ENTRIES = 1 << CODE_W;

    typedef logic [RIGHT_W-1:0] rights_t;

    typedef enum logic [KIND_W-1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_kind_e;

    typedef enum logic [1:0] {
        FLT_NONE     = 2'd0,
        FLT_ABSENT   = 2'd1,
        FLT_NO_RIGHT = 2'd2
    } fault_e;

    typedef struct packed {
        logic   valid;
        logic   allow;
        fault_e fault;
    } result_t;

    // Hierarchical power-up contents: the low two code bits pick a
    // rights class, the high bits widen it downward from kernel.
    function automatic rights_t reset_rights(input int lvl, input int code);
        rights_t cls;
        int      spread;
        case (code % 4)
            0:       cls = 3'b001;
            1:       cls = 3'b101;
            2:       cls = 3'b011;
            default: cls = 3'b111;
        endcase
        spread = code / 4;
        if (lvl >= (NUM_LVL - 1 - spread)) begin
            return cls;
        end
        return '0;
    endfunction

endpackage

// File: rtl/perm_level_bank.sv
module perm_level_bank
    import perm_pkg::*;
#(
    parameter int LEVEL = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CODE_W-1:0] wr_idx,
    input  rights_t           wr_data,
    input  logic              rd_en,
    input  logic [CODE_W-1:0] rd_idx,
    output rights_t           rd_data
);

    typedef struct packed {
        logic [ENTRIES-1:0][RIGHT_W-1:0] mem;
    } bank_state_t;

    bank_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.mem[wr_idx] = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                st_q.mem[i] <= reset_rights(LEVEL, i);
            end
        end else begin
            st_q <= st_d;
        end
    end

    // Read port sees the registered contents, so a write in the same
    // cycle is not visible to the read until the next cycle.
    always_comb begin
        rd_data = '0;
        if (rd_en) begin
            rd_data = st_q.mem[rd_idx];
        end
    end

    // R6: a write lands in the addressed triple
    a_r6_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> st_q.mem[$past(wr_idx)] == $past(wr_data));

    // R6: without a write the bank keeps its contents
    a_r6_bank_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(st_q));

endmodule

// File: rtl/perm_eval.sv
module perm_eval
    import perm_pkg::*;
(
    input  logic              present,
    input  logic [KIND_W-1:0] kind,
    input  rights_t           rights,
    output logic              allow,
    output fault_e            fault
);

    logic kind_ok;
    logic right_bit;

    always_comb begin
        kind_ok   = (kind != ACC_RSVD);
        right_bit = 1'b0;
        if (kind_ok) begin
            right_bit = rights[kind];
        end
        allow = present && right_bit;
        if (!present) begin
            fault = FLT_ABSENT;
        end else if (!right_bit) begin
            fault = FLT_NO_RIGHT;
        end else begin
            fault = FLT_NONE;
        end
    end

endmodule

// File: rtl/perm_checker.sv
module perm_checker
    import perm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CODE_W-1:0] wr_idx,
    input  logic [LVL_W-1:0]  wr_lvl,
    input  logic [RIGHT_W-1:0] wr_rights,
    input  logic              chk_valid,
    input  logic [CODE_W-1:0] chk_code,
    input  logic              chk_present,
    input  logic [LVL_W-1:0]  chk_lvl,
    input  logic [KIND_W-1:0] chk_kind,
    output logic              res_valid,
    output logic              res_allow,
    output logic [1:0]        res_fault
);

    logic [NUM_LVL-1:0]              bank_wr_en;
    logic [NUM_LVL-1:0]              bank_rd_en;
    logic [NUM_LVL-1:0][RIGHT_W-1:0] bank_rd;
    rights_t                         sel_rights;
    logic                            ev_allow;
    fault_e                          ev_fault;
    result_t                         res_d, res_q;

    for (genvar g = 0; g < NUM_LVL; g++) begin : g_bank
        assign bank_wr_en[g] = wr_en && (wr_lvl == LVL_W'(g));
        assign bank_rd_en[g] = chk_valid && (chk_lvl == LVL_W'(g));

        perm_level_bank #(
            .LEVEL (g)
        ) i_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (bank_wr_en[g]),
            .wr_idx  (wr_idx),
            .wr_data (wr_rights),
            .rd_en   (bank_rd_en[g]),
            .rd_idx  (chk_code),
            .rd_data (bank_rd[g])
        );
    end

    always_comb begin
        sel_rights = '0;
        for (int i = 0; i < NUM_LVL; i++) begin
            sel_rights = sel_rights | bank_rd[i];
        end
    end

    perm_eval i_eval (
        .present (chk_present),
        .kind    (chk_kind),
        .rights  (sel_rights),
        .allow   (ev_allow),
        .fault   (ev_fault)
    );

    always_comb begin
        res_d = '0;
        if (chk_valid) begin
            res_d.valid = 1'b1;
            res_d.allow = ev_allow;
            res_d.fault = ev_fault;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign res_valid = res_q.valid;
    assign res_allow = res_q.allow;
    assign res_fault = res_q.fault;

    // R3: at most one level bank is read per cycle
    a_r3_single_bank: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bank_rd_en));

    // R2: request answered on the next cycle
    a_r2_result_follows: assert property (@(posedge clk) disable iff (!rst_n)
        chk_valid |=> res_valid);

    // R2: idle cycle yields a quiet result
    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_valid |=> (!res_valid && !res_allow && res_fault == 2'd0));

    // R4: absent page is always denied
    a_r4_absent_denied: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_valid && !chk_present) |=> (!res_allow && res_fault == 2'd1));

    // R5: reserved kind is never allowed
    a_r5_reserved_kind: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_valid && chk_present && chk_kind == 2'd3)
        |=> (!res_allow && res_fault == 2'd2));

    // R3: an allowed result carries no fault reason
    a_r3_allow_clean: assert property (@(posedge clk) disable iff (!rst_n)
        res_allow |-> (res_valid && res_fault == 2'd0));

endmodule

// File: tb/test_perm_checker.sv
module test_perm_checker;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] wr_idx = '0;
    logic [1:0] wr_lvl = '0;
    logic [2:0] wr_rights = '0;
    logic       chk_valid = 1'b0;
    logic [3:0] chk_code = '0;
    logic       chk_present = 1'b0;
    logic [1:0] chk_lvl = '0;
    logic [1:0] chk_kind = '0;
    logic       res_valid;
    logic       res_allow;
    logic [1:0] res_fault;

    int errors = 0;
    int checks = 0;
    logic [2:0] model [4][16];

    always #2.5 clk = ~clk;

    perm_checker i_perm_checker (
        .clk, .rst_n, .wr_en, .wr_idx, .wr_lvl, .wr_rights,
        .chk_valid, .chk_code, .chk_present, .chk_lvl, .chk_kind,
        .res_valid, .res_allow, .res_fault
    );

    task automatic judge(input string req, input logic ev, input logic ea,
                         input logic [1:0] ef);
        checks++;
        if (res_valid !== ev || res_allow !== ea || res_fault !== ef) begin
            errors++;
            $display("FAIL %s: got valid=%0b allow=%0b fault=%0d expected valid=%0b allow=%0b fault=%0d",
                     req, res_valid, res_allow, res_fault, ev, ea, ef);
        end
    endtask

    function automatic logic [2:0] expected_fault(input logic pres, input logic ok);
        if (!pres) return 3'd1;
        if (!ok) return 3'd2;
        return 3'd0;
    endfunction

    task automatic do_check(input string req, input int code, input int lvl,
                            input int kind, input logic pres);
        logic ok;
        logic [2:0] ef;
        ok = (kind != 3) && model[lvl][code][kind];
        ef = expected_fault(pres, ok);
        chk_valid   = 1'b1;
        chk_code    = 4'(code);
        chk_lvl     = 2'(lvl);
        chk_kind    = 2'(kind);
        chk_present = pres;
        @(negedge clk);
        chk_valid = 1'b0;
        judge(req, 1'b1, pres && ok, ef[1:0]);
    endtask

    task automatic do_write(input int code, input int lvl, input logic [2:0] r);
        wr_en = 1'b1; wr_idx = 4'(code); wr_lvl = 2'(lvl); wr_rights = r;
        @(negedge clk);
        wr_en = 1'b0;
        model[lvl][code] = r;
    endtask

    task automatic sweep(input string req);
        for (int c = 0; c < 16; c++)
            for (int l = 0; l < 4; l++)
                for (int k = 0; k < 4; k++)
                    do_check(req, c, l, k, 1'b1);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R1: reset contents computed arithmetically
        for (int c = 0; c < 16; c++) begin
            for (int l = 0; l < 4; l++) begin
                int cls;
                cls = c % 4;
                if (l >= 3 - c / 4) model[l][c] = {1'(cls % 2), 1'(cls / 2), 1'b1};
                else model[l][c] = 3'b000;
            end
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        judge("R2 reset state", 1'b0, 1'b0, 2'd0);

        sweep("R1/R3/R5 reset table");

        // R2: idle cycle after a request
        @(negedge clk);
        judge("R2 idle", 1'b0, 1'b0, 2'd0);

        // R4: absent page, every code and level
        for (int c = 0; c < 16; c++)
            for (int l = 0; l < 4; l++)
                do_check("R4 absent", c, l, (c + l) % 3, 1'b0);

        // R6: full reload with a computed pattern
        for (int c = 0; c < 16; c++)
            for (int l = 0; l < 4; l++)
                do_write(c, l, 3'((c * 3 + l * 5 + 1) % 8));
        sweep("R6/R3 reloaded table");

        // R6: single triple update leaves neighbours alone
        do_write(9, 1, ~model[1][9]);
        for (int l = 0; l < 4; l++)
            for (int k = 0; k < 3; k++) begin
                do_check("R6 partial update", 9, l, k, 1'b1);
                do_check("R6 neighbour code", 8, l, k, 1'b1);
            end

        // R7: write and check collide on the same triple
        model[2][5] = 3'b000;
        do_write(5, 2, 3'b000);
        wr_en = 1'b1; wr_idx = 4'd5; wr_lvl = 2'd2; wr_rights = 3'b111;
        chk_valid = 1'b1; chk_code = 4'd5; chk_lvl = 2'd2;
        chk_kind = 2'd1; chk_present = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; chk_valid = 1'b0;
        judge("R7 collision old rights", 1'b1, 1'b0, 2'd2);
        model[2][5] = 3'b111;
        do_check("R7 after collision new rights", 5, 2, 1, 1'b1);
        do_check("R5 reserved kind full rights", 5, 2, 3, 1'b1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule